// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the 256-byte configuration space of one single-function endpoint. A configuration agent reads whole dwords by a six-bit dword index and writes dwords with per-byte enables. Identity values (vendor, device, class, revision, interrupt pin, grant and latency limits, capability pointer) are fixed by parameters. Writable fields follow their own rules: hardwired command bits, write-one-to-clear status error bits, naturally aligned base address registers whose low bits are fixed, and a cache-line-size field that only keeps supported values.

The block drives the decode enables (I/O, memory, bus master), the interrupt-disable bit, a gated legacy interrupt output and the decoded base address of each BAR to a downstream address decoder. Error events from the bus logic arrive as one-cycle pulses and are latched into the status register.

Top module: `cfg_type0_hdr`

## Requirements
- R1: A read strobe on `cfg_rd` returns the addressed dword on `cfg_rdata` with `cfg_rvalid` high exactly one cycle later; `cfg_rvalid` is low in any cycle after a cycle without a read strobe.
- R2: Dword 0 reads {device ID, vendor ID} (device in bits 31:16); dword 2 reads class, subclass, programming interface, revision from byte 3 down to byte 0; in dword 3 the header-type byte (bits 23:16) reads 0x00 with its multi-function bit 7 clear and the self-test byte (bits 31:24) reads 0x00; writes to these fields have no effect.
- R3: The command register (dword 1 bits 15:0) keeps written values in bits 0-6 and 8-10; bit 7 and bits 15:11 read 0. Outputs `io_dec_en`, `mem_dec_en`, `master_en`, `irq_disable` follow command bits 0, 1, 2 and 10; writing 0 clears all of them.
- R4: Status bits 15..11 and 8 (dword 1 bits 31..27 and 24) are set by `err_event[5..1]` and `err_event[0]` respectively, stay set, and clear only when written with 1 while their byte is enabled; an event in the same cycle as a clear wins.
- R5: Status bit 3 (dword 1 bit 19) follows `irq_req`; `intx_out` is high only when `irq_req` is high and command bit 10 is clear.
- R6: Status bit 4 (dword 1 bit 20) is 1 when the capability pointer parameter is non-zero; dword 0x0D reads the pointer in bits 7:0 with bits 1:0 forced to 0 and all other bits 0. Status bits 10:9 read the select-timing parameter; bits 7:5 and 2:0 read 0.
- R7: A memory BAR reads bit 0 = 0, bits 2:1 = 00, bit 3 = prefetchable parameter; only bits at and above its size exponent are writable (default BAR0 at dword 4: 16 MB, prefetchable, so writing all ones reads 0xFF000008).
- R8: An I/O BAR reads bit 0 = 1 and bit 1 = 0; only bits at and above its size exponent are writable (default BAR1 at dword 5: 256 bytes, so writing all ones reads 0xFFFFFF01).
- R9: `bar_base` slice i carries BAR i with its flag bits cleared.
- R10: The cache-line-size byte (dword 3 bits 7:0) keeps a written value only if it is in the supported list (default 8 and 16); any other written value leaves it 0. The latency-timer byte (bits 15:8) is freely writable.
- R11: Dword 0x0F reads {max latency, min grant, interrupt pin, interrupt line}; only the interrupt line byte is writable. The pin encodes 0 = none, 1..4 = INTA..INTD (default 1).
- R12: A write changes only bytes whose enable bit is set.
- R13: Dword indices with no register (including BAR slots past the configured count) read 0 and ignore writes.
- R14: After reset the command, error status bits, BAR bases, cache line size, latency timer and interrupt line are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd | input | 1 | Read strobe for dword `cfg_idx` |
| cfg_wr | input | 1 | Write strobe for dword `cfg_idx` |
| cfg_idx | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with `cfg_rvalid` |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| err_event | input | 6 | Error event pulses latched into status |
| irq_req | input | 1 | Internal interrupt request level |
| io_dec_en | output | 1 | I/O decode enable |
| mem_dec_en | output | 1 | Memory decode enable |
| master_en | output | 1 | Bus master enable |
| irq_disable | output | 1 | Interrupt disable bit |
| intx_out | output | 1 | Gated legacy interrupt request |
| bar_base | output | NUM_BARS*32 | Decoded BAR base addresses, BAR i in bits 32i+31:32i |

## Verification
The hardest situation to reach is an error event landing in the same cycle as a write-one-to-clear of that very status bit, since both come from independent sources; the bench drives the event pulse and the clearing write from the same falling edge so they meet at one rising edge, then reads the status back. The size probe of each BAR is also exercised with partial byte enables, so that a byte containing only hardwired bits is written and shown unchanged.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   localparam int unsigned DW       = 32;
   localparam int unsigned IDX_W    = 6;
   localparam int unsigned MAX_BARS = 6;

   localparam logic [IDX_W-1:0] IDX_ID      = 6'h00;
   localparam logic [IDX_W-1:0] IDX_CMDSTAT = 6'h01;
   localparam logic [IDX_W-1:0] IDX_CLASS   = 6'h02;
   localparam logic [IDX_W-1:0] IDX_MISC    = 6'h03;
   localparam logic [IDX_W-1:0] IDX_BAR0    = 6'h04;
   localparam logic [IDX_W-1:0] IDX_CAP     = 6'h0D;
   localparam logic [IDX_W-1:0] IDX_INTR    = 6'h0F;

   localparam logic [15:0] CMD_WMASK = 16'h077F;
   localparam logic [15:0] STAT_W1C  = 16'hF900;
   localparam logic [7:0]  HDR_TYPE  = 8'h00;

   typedef logic [DW-1:0] dword_t;

   function automatic dword_t be_to_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/cfg_bar.sv
module cfg_bar
   import cfg_hdr_pkg::*;
#(
   parameter bit          IS_IO   = 1'b0,
   parameter bit          PREF    = 1'b0,
   parameter int unsigned SZ_LOG2 = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rd_val,
   output logic [31:0] base
);

   localparam int unsigned MIN_SZ = IS_IO ? 2 : 4;
   localparam dword_t WMASK = ~((32'h1 << SZ_LOG2) - 32'h1);
   localparam dword_t FLAGS = IS_IO ? 32'h1 : (PREF ? 32'h8 : 32'h0);

   if (SZ_LOG2 < MIN_SZ || SZ_LOG2 > 31) begin : g_bad_size
      $error("cfg_bar: size exponent out of range");
   end

   dword_t base_q;
   dword_t wmask;

   assign wmask = be_to_mask(be) & WMASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_en) begin
         base_q <= (base_q & ~wmask) | (wdata & wmask);
      end
   end

   assign base   = base_q;
   assign rd_val = base_q | FLAGS;

   assert_bar_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be == 4'hF) |=> (base == ($past(wdata) & WMASK)));

   assert_bar_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be == 4'h0) |=> $stable(base));

endmodule

// File: rtl/cfg_cls_reg.sv
module cfg_cls_reg #(
   parameter int unsigned            CLS_NUM  = 2,
   parameter logic [CLS_NUM*8-1:0]   CLS_LIST = {8'd16, 8'd8}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic [7:0] cls_q
);

   if (CLS_NUM < 1) begin : g_bad_list
      $error("cfg_cls_reg: supported list is empty");
   end

   logic [CLS_NUM-1:0] hit;

   for (genvar g = 0; g < CLS_NUM; g++) begin : g_cmp
      assign hit[g] = (wdata == CLS_LIST[g*8 +: 8]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q <= '0;
      end else if (wr_en) begin
         cls_q <= (|hit) ? wdata : 8'h00;
      end
   end

   assert_cls_fallback_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(|hit)) |=> (cls_q == 8'h00));

endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
   import cfg_hdr_pkg::*;
#(
   parameter bit         CAP_PRESENT = 1'b1,
   parameter logic [1:0] DEVSEL_T    = 2'b01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic [5:0]  err_event,
   input  logic        irq_req,
   output logic [15:0] cmd_q,
   output logic [15:0] stat_rd
);

   logic [15:0] err_q;
   logic [15:0] cmd_wm;
   logic [15:0] set16;
   logic [15:0] clr16;

   assign cmd_wm = wr_en ? ({{8{be[1]}}, {8{be[0]}}} & CMD_WMASK) : 16'h0000;
   assign set16  = {err_event[5:1], 2'b00, err_event[0], 8'h00};
   assign clr16  = wr_en ? (wdata[31:16] & {{8{be[3]}}, {8{be[2]}}} & STAT_W1C)
                         : 16'h0000;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         err_q <= '0;
      end else begin
         cmd_q <= (cmd_q & ~cmd_wm) | (wdata[15:0] & cmd_wm);
         err_q <= ((err_q & ~clr16) | set16) & STAT_W1C;
      end
   end

   assign stat_rd = err_q | {5'b00000, DEVSEL_T, 4'b0000, CAP_PRESENT, irq_req, 3'b000};

   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[3] && wdata[31] && !err_event[5]) |=> !stat_rd[15]);

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[14] && !(wr_en && be[3] && wdata[30])) |=> stat_rd[14]);

   assert_cmd_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be[0] && wdata[7]) |=> !cmd_q[7]);

endmodule

// File: rtl/cfg_type0_hdr.sv
module cfg_type0_hdr
   import cfg_hdr_pkg::*;
#(
   parameter logic [15:0]            VENDOR_ID   = 16'hABCD,
   parameter logic [15:0]            DEVICE_ID   = 16'h1234,
   parameter logic [23:0]            CLASS_CODE  = 24'h020000,
   parameter logic [7:0]             REVISION    = 8'h03,
   parameter int unsigned            NUM_BARS    = 2,
   parameter logic [NUM_BARS-1:0]    BAR_IS_IO   = 2'b10,
   parameter logic [NUM_BARS-1:0]    BAR_PREF    = 2'b01,
   parameter logic [NUM_BARS*8-1:0]  BAR_SZ_LOG2 = {8'd8, 8'd24},
   parameter int unsigned            CLS_NUM     = 2,
   parameter logic [CLS_NUM*8-1:0]   CLS_LIST    = {8'd16, 8'd8},
   parameter logic [7:0]             CAP_PTR     = 8'h43,
   parameter logic [7:0]             INT_PIN     = 8'h01,
   parameter logic [7:0]             MIN_GNT     = 8'h02,
   parameter logic [7:0]             MAX_LAT     = 8'h10,
   parameter logic [1:0]             DEVSEL_T    = 2'b01
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_rd,
   input  logic                     cfg_wr,
   input  logic [5:0]               cfg_idx,
   input  logic [3:0]               cfg_be,
   input  logic [31:0]              cfg_wdata,
   output logic [31:0]              cfg_rdata,
   output logic                     cfg_rvalid,
   input  logic [5:0]               err_event,
   input  logic                     irq_req,
   output logic                     io_dec_en,
   output logic                     mem_dec_en,
   output logic                     master_en,
   output logic                     irq_disable,
   output logic                     intx_out,
   output logic [NUM_BARS*32-1:0]   bar_base
);

   localparam bit         CAP_PRESENT = (CAP_PTR != 8'h00);
   localparam logic [7:0] CAP_RD      = CAP_PTR & 8'hFC;

   if (NUM_BARS < 1 || NUM_BARS > MAX_BARS) begin : g_bad_bars
      $error("cfg_type0_hdr: BAR count out of range");
   end
   if (INT_PIN > 8'h04) begin : g_bad_pin
      $error("cfg_type0_hdr: interrupt pin code out of range");
   end

   logic [15:0] cmd_q;
   logic [15:0] stat_rd;
   logic [7:0]  cls_q;
   logic [7:0]  lat_q;
   logic [7:0]  int_line_q;
   dword_t      bar_rd [NUM_BARS];
   dword_t      rd_mux;

   logic wr_cmdstat, wr_misc, wr_intr;
   assign wr_cmdstat = cfg_wr && (cfg_idx == IDX_CMDSTAT);
   assign wr_misc    = cfg_wr && (cfg_idx == IDX_MISC);
   assign wr_intr    = cfg_wr && (cfg_idx == IDX_INTR);

   cfg_cmd_status #(
      .CAP_PRESENT (CAP_PRESENT),
      .DEVSEL_T    (DEVSEL_T)
   ) i_cmd_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_cmdstat),
      .be        (cfg_be),
      .wdata     (cfg_wdata),
      .err_event (err_event),
      .irq_req   (irq_req),
      .cmd_q     (cmd_q),
      .stat_rd   (stat_rd)
   );

   cfg_cls_reg #(
      .CLS_NUM  (CLS_NUM),
      .CLS_LIST (CLS_LIST)
   ) i_cls (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_misc && cfg_be[0]),
      .wdata (cfg_wdata[7:0]),
      .cls_q (cls_q)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      logic we;
      assign we = cfg_wr && (cfg_idx == 6'(int'(IDX_BAR0) + i));
      cfg_bar #(
         .IS_IO   (BAR_IS_IO[i]),
         .PREF    (BAR_PREF[i]),
         .SZ_LOG2 (int'(BAR_SZ_LOG2[i*8 +: 8]))
      ) i_bar (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (we),
         .be     (cfg_be),
         .wdata  (cfg_wdata),
         .rd_val (bar_rd[i]),
         .base   (bar_base[i*32 +: 32])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q      <= '0;
         int_line_q <= '0;
      end else begin
         if (wr_misc && cfg_be[1]) lat_q      <= cfg_wdata[15:8];
         if (wr_intr && cfg_be[0]) int_line_q <= cfg_wdata[7:0];
      end
   end

   always_comb begin
      case (cfg_idx)
         IDX_ID:      rd_mux = {DEVICE_ID, VENDOR_ID};
         IDX_CMDSTAT: rd_mux = {stat_rd, cmd_q};
         IDX_CLASS:   rd_mux = {CLASS_CODE, REVISION};
         IDX_MISC:    rd_mux = {8'h00, HDR_TYPE, lat_q, cls_q};
         IDX_CAP:     rd_mux = {24'h000000, CAP_RD};
         IDX_INTR:    rd_mux = {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
         default:     rd_mux = '0;
      endcase
      for (int i = 0; i < NUM_BARS; i++) begin
         if (cfg_idx == 6'(int'(IDX_BAR0) + i)) rd_mux = bar_rd[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rvalid <= 1'b0;
         cfg_rdata  <= '0;
      end else begin
         cfg_rvalid <= cfg_rd;
         if (cfg_rd) cfg_rdata <= rd_mux;
      end
   end

   assign io_dec_en   = cmd_q[0];
   assign mem_dec_en  = cmd_q[1];
   assign master_en   = cmd_q[2];
   assign irq_disable = cmd_q[10];
   assign intx_out    = irq_req & ~cmd_q[10];

   assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd |=> cfg_rvalid);

   assert_rd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> !cfg_rvalid);

   assert_intx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmdstat && cfg_be[1] && cfg_wdata[10]) |=> !intx_out);

   assert_cmd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmdstat && cfg_be[1:0] == 2'b11 && cfg_wdata[15:0] == 16'h0000)
      |=> !(io_dec_en || mem_dec_en || master_en));

endmodule

// File: tb/test_cfg_type0_hdr.sv
module test_cfg_type0_hdr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_rd = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_idx = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_rvalid;
   logic [5:0]  err_event = '0;
   logic        irq_req = 1'b0;
   logic        io_dec_en, mem_dec_en, master_en, irq_disable, intx_out;
   logic [63:0] bar_base;

   cfg_type0_hdr i_cfg_type0_hdr (
      .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
      .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
      .err_event(err_event), .irq_req(irq_req),
      .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en), .master_en(master_en),
      .irq_disable(irq_disable), .intx_out(intx_out), .bar_base(bar_base)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_read(input logic [5:0] idx, input logic [31:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
      cfg_rd = 1'b1; cfg_idx = idx;
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   // monitor: compare returned reads in order
   always @(negedge clk) begin
      if (rst_n && cfg_rvalid) begin
         if (sb_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1 unexpected read data: actual 0x%0h expected none", cfg_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, {32'h0, cfg_rdata}, {32'h0, e.exp});
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R14 decode enables", {60'h0, io_dec_en, mem_dec_en, master_en, irq_disable}, 64'h0);
      check("R14 bar_base", bar_base, 64'h0);
      check("R5 intx idle", {63'h0, intx_out}, 64'h0);
      check("R1 rvalid idle", {63'h0, cfg_rvalid}, 64'h0);
      cfg_read(6'h01, 32'h0210_0000, "R14 R6 cmd/status reset");
      cfg_read(6'h04, 32'h0000_0008, "R14 R7 bar0 reset");
      cfg_read(6'h05, 32'h0000_0001, "R14 R8 bar1 reset");
      cfg_read(6'h03, 32'h0000_0000, "R14 R2 dword3 reset");

      // identity
      cfg_read(6'h00, 32'h1234_ABCD, "R2 id dword");
      cfg_read(6'h02, 32'h0200_0003, "R2 class dword");
      cfg_write(6'h00, 4'hF, 32'h0);
      cfg_read(6'h00, 32'h1234_ABCD, "R2 id write ignored");

      // command register
      cfg_write(6'h01, 4'b0011, 32'hFFFF_FFFF);
      cfg_read(6'h01, 32'h0210_077F, "R3 cmd writable bits");
      check("R3 enables on", {60'h0, io_dec_en, mem_dec_en, master_en, irq_disable}, 64'hF);
      cfg_write(6'h01, 4'b0011, 32'h0);
      cfg_read(6'h01, 32'h0210_0000, "R3 cmd cleared");
      check("R3 zero disables", {60'h0, io_dec_en, mem_dec_en, master_en, irq_disable}, 64'h0);

      // byte enables on command
      cfg_write(6'h01, 4'b0001, 32'hFFFF_FF03);
      cfg_read(6'h01, 32'h0210_0003, "R12 low byte only");
      cfg_write(6'h01, 4'b0010, 32'h0000_0400);
      cfg_read(6'h01, 32'h0210_0403, "R12 high byte only");
      cfg_write(6'h01, 4'b0000, 32'hFFFF_FFFF);
      cfg_read(6'h01, 32'h0210_0403, "R12 no enables");
      cfg_write(6'h01, 4'b0011, 32'h0);

      // interrupt gating
      @(negedge clk); irq_req = 1'b1;
      @(negedge clk);
      check("R5 intx follows irq", {63'h0, intx_out}, 64'h1);
      cfg_read(6'h01, 32'h0218_0000, "R5 status irq bit");
      cfg_write(6'h01, 4'b0010, 32'h0000_0400);
      check("R5 intx gated", {63'h0, intx_out}, 64'h0);
      cfg_read(6'h01, 32'h0218_0400, "R5 status irq while disabled");
      cfg_write(6'h01, 4'b0011, 32'h0);
      @(negedge clk); irq_req = 1'b0;

      // sticky error bits
      @(negedge clk); err_event = 6'h3F;
      @(negedge clk); err_event = 6'h00;
      cfg_read(6'h01, 32'hFB10_0000, "R4 errors set");
      cfg_read(6'h01, 32'hFB10_0000, "R4 errors sticky");
      cfg_write(6'h01, 4'b1100, 32'h8100_0000);
      cfg_read(6'h01, 32'h7A10_0000, "R4 w1c bits 15 and 8");
      cfg_write(6'h01, 4'b0100, 32'h4000_0000);
      cfg_read(6'h01, 32'h7A10_0000, "R4 clear needs byte enable");
      // event and clear of bit 14 in the same cycle
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = 6'h01; cfg_be = 4'b1000; cfg_wdata = 32'h4000_0000;
      err_event = 6'b010000;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; err_event = '0;
      cfg_read(6'h01, 32'h7A10_0000, "R4 event beats clear");
      cfg_write(6'h01, 4'b1100, 32'hFFFF_0000);
      cfg_read(6'h01, 32'h0210_0000, "R4 all cleared");

      // memory BAR
      cfg_write(6'h04, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h04, 32'hFF00_0008, "R7 bar0 size probe");
      check("R9 bar0 base", {32'h0, bar_base[31:0]}, 64'hFF00_0000);
      cfg_write(6'h04, 4'hF, 32'h1234_5670);
      cfg_read(6'h04, 32'h1200_0008, "R7 bar0 aligned write");
      cfg_write(6'h04, 4'b0001, 32'h0000_00FF);
      cfg_read(6'h04, 32'h1200_0008, "R12 bar0 fixed byte");
      cfg_write(6'h04, 4'b1000, 32'hAB00_0000);
      cfg_read(6'h04, 32'hAB00_0008, "R12 bar0 top byte");

      // I/O BAR
      cfg_write(6'h05, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h05, 32'hFFFF_FF01, "R8 bar1 size probe");
      check("R9 bar1 base", {32'h0, bar_base[63:32]}, 64'hFFFF_FF00);
      cfg_write(6'h05, 4'hF, 32'h0000_C0FF);
      cfg_read(6'h05, 32'h0000_C001, "R8 bar1 aligned write");
      check("R9 bar0 unchanged", {32'h0, bar_base[31:0]}, 64'hAB00_0000);

      // cache line size and latency
      cfg_write(6'h03, 4'b0001, 32'h0000_0010);
      cfg_read(6'h03, 32'h0000_0010, "R10 cls 16 kept");
      cfg_write(6'h03, 4'b0001, 32'h0000_000C);
      cfg_read(6'h03, 32'h0000_0000, "R10 cls 12 falls back");
      cfg_write(6'h03, 4'b0001, 32'h0000_0008);
      cfg_write(6'h03, 4'b0010, 32'h0000_4000);
      cfg_read(6'h03, 32'h0000_4008, "R10 cls 8 and latency");
      cfg_write(6'h03, 4'b1100, 32'hFFFF_0000);
      cfg_read(6'h03, 32'h0000_4008, "R2 header and selftest read-only");

      // capability pointer
      cfg_read(6'h0D, 32'h0000_0040, "R6 cap pointer low bits");
      cfg_write(6'h0D, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h0D, 32'h0000_0040, "R6 cap pointer read-only");

      // interrupt dword
      cfg_write(6'h0F, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h0F, 32'h1002_01FF, "R11 interrupt dword");

      // unimplemented
      cfg_write(6'h0A, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h0A, 32'h0, "R13 unimplemented dword");
      cfg_write(6'h06, 4'hF, 32'hFFFF_FFFF);
      cfg_read(6'h06, 32'h0, "R13 unused BAR slot");
      cfg_read(6'h3F, 32'h0, "R13 last dword");
      check("R13 outputs untouched", {60'h0, io_dec_en, mem_dec_en, master_en, irq_disable}, 64'h0);

      // back-to-back reads
      cfg_read(6'h00, 32'h1234_ABCD, "R1 back-to-back a");
      cfg_read(6'h02, 32'h0200_0003, "R1 back-to-back b");
      @(negedge clk);
      check("R1 rvalid drops", {63'h0, cfg_rvalid}, 64'h0);
      check("R1 scoreboard drained", 64'(sb_q.size()), 64'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule